// File: doc/BRIEF.md
# Event Store with Selectable Roll Mode

This block is the event storage and readout controller of one multi-channel front-end readout chip. An external controller walks it through four phases: idle, acquisition, conversion and readout. During acquisition, each trigger writes one event into a fixed-depth event memory. An event holds the channel hit bits and a bunch-crossing tag, which is the number of acquisition cycles that have passed since the acquisition began.

A configuration input sets what happens once the memory fills. In fill-once mode the block keeps the earliest events, drops every later trigger and raises a full flag so that the controller can end the acquisition. In roll mode the memory works as a ring: the newest event overwrites the oldest one, so the most recent events survive, and the full flag stays low.

Readout is daisy chained. When the readout token reaches the chip during the readout phase, the chip shifts out a stored-event count and then the events, oldest first, on one serial line. It then hands the token to the next chip. It does this even when it holds no events.

Top module: `event_store_roll`

## Requirements
- R1: While `phase` is 1 (acquisition), a cycle with `trigValid` high stores one event made of `trigHits` and a 12-bit tag. The tag equals the number of acquisition cycles before this one in the current acquisition, so the first acquisition cycle has tag 0.
- R2: With `rollMode` low, only the first DEPTH events of an acquisition are kept, and later triggers are dropped.
- R3: With `rollMode` high, the memory keeps the last DEPTH events, and each new event overwrites the oldest one.
- R4: `memFull` is high exactly when `rollMode` is low and DEPTH events are stored. It is never high while `rollMode` is high.
- R5: The first cycle of an acquisition clears the stored count, the write position and `memFull`, so `memFull` is low in the following cycle.
- R6: A trigger while `phase` is not 1 stores nothing.
- R7: A `tokenIn` pulse while `phase` is 3 (readout) starts a frame on `dataOut`, sent MSB first with `dataValid` high on every frame bit. The frame holds a 7-bit stored-event count, then each event from oldest to newest. Each event is its 12-bit tag followed by its 8 hit bits.
- R8: `tokenOut` pulses high for one cycle, in the cycle after the last frame bit. A frame with a zero count consists of the count field alone and still passes the token.
- R9: A `tokenIn` pulse while `phase` is not 3 starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rollMode | input | 1 | 0 keeps the first events, 1 keeps the last events |
| phase | input | 2 | 0 idle, 1 acquisition, 2 conversion, 3 readout |
| trigValid | input | 1 | Trigger strobe |
| trigHits | input | CHANNELS | Channel hit bits of the trigger |
| tokenIn | input | 1 | Readout token from the previous chip |
| memFull | output | 1 | Memory full in fill-once mode |
| dataOut | output | 1 | Serial readout data |
| dataValid | output | 1 | High on every frame bit |
| tokenOut | output | 1 | Token pulse to the next chip |

## Verification
The assertions take for granted that the controller keeps `phase` at readout until the token has passed, that `tokenIn` is a single-cycle pulse, and that `rollMode` stays constant within one acquisition. The occupancy model in the checker depends on that last point. The bench changes `rollMode` only while the block is idle, holds the readout phase until it sees `tokenOut`, and sends the token only between frames. It also injects triggers in the conversion phase and tokens outside the readout phase, so that the ignore rules are exercised without breaking those assumptions.

// File: rtl/evs_pkg.sv
package evs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_READ = 2'd3
  } phase_e;

  typedef struct packed {
    logic wrEn;
    logic loadCnt;
    logic loadEv;
    logic shiftEn;
  } strobe_t;
endpackage

// File: rtl/evs_ctrl.sv
module evs_ctrl
  import evs_pkg::*;
#(
  parameter int DEPTH  = 127,
  parameter int BCID_W = 12,
  parameter int EV_W   = 20,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rollMode,
  input  logic [1:0]        phase,
  input  logic              trigValid,
  input  logic              tokenIn,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [BCID_W-1:0] tag,
  output logic [CNT_W-1:0]  evCount,
  output logic              memFull,
  output logic              dataValid,
  output logic              tokenOut
);
  localparam int SH_W  = (EV_W > CNT_W) ? EV_W : CNT_W;
  localparam int BIT_W = $clog2(SH_W + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  typedef enum logic [1:0] {RD_IDLE, RD_SEND, RD_PASS} rd_e;

  logic [1:0]        prevPhase;
  logic [ADDR_W-1:0] wrPtr, wrBase, rdPtr;
  logic [CNT_W-1:0]  count, cntBase, evLeft;
  logic [BCID_W-1:0] bcidCnt;
  logic [BIT_W-1:0]  bitsLeft;
  rd_e               rdState;
  logic              inAcq, acqEntry, canWrite, rdStart, lastBit;

  assign inAcq    = (phase == PH_ACQ);
  assign acqEntry = inAcq && (prevPhase != PH_ACQ);
  assign wrBase   = acqEntry ? '0 : wrPtr;
  assign cntBase  = acqEntry ? '0 : count;
  assign canWrite = inAcq && trigValid && (rollMode || cntBase != FULL_CNT);
  assign tag      = acqEntry ? '0 : bcidCnt;
  assign wrAddr   = wrBase;
  assign rdAddr   = rdPtr;
  assign evCount  = count;
  assign memFull  = !rollMode && (count == FULL_CNT);

  assign rdStart   = (rdState == RD_IDLE) && tokenIn && (phase == PH_READ);
  assign lastBit   = (bitsLeft == BIT_W'(1));
  assign dataValid = (rdState == RD_SEND);
  assign tokenOut  = (rdState == RD_PASS);

  always_comb begin
    strb         = '0;
    strb.wrEn    = canWrite;
    strb.loadCnt = rdStart;
    if (rdState == RD_SEND) begin
      if (lastBit && evLeft != '0) strb.loadEv  = 1'b1;
      else                         strb.shiftEn = 1'b1;
    end
  end

  // acquisition side: pointers, occupancy, bunch-crossing tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= PH_IDLE;
      wrPtr     <= '0;
      count     <= '0;
      bcidCnt   <= '0;
    end else begin
      prevPhase <= phase;
      if (inAcq) begin
        bcidCnt <= acqEntry ? BCID_W'(1) : bcidCnt + BCID_W'(1);
        if (canWrite) begin
          wrPtr <= (wrBase == LAST_ADDR) ? '0 : wrBase + ADDR_W'(1);
          count <= (cntBase == FULL_CNT) ? cntBase : cntBase + CNT_W'(1);
        end else begin
          wrPtr <= wrBase;
          count <= cntBase;
        end
      end
    end
  end

  // readout side: count field, then events oldest first, then token
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdState  <= RD_IDLE;
      rdPtr    <= '0;
      evLeft   <= '0;
      bitsLeft <= '0;
    end else begin
      case (rdState)
        RD_IDLE: if (rdStart) begin
          rdPtr    <= (rollMode && count == FULL_CNT) ? wrPtr : '0;
          evLeft   <= count;
          bitsLeft <= BIT_W'(CNT_W);
          rdState  <= RD_SEND;
        end
        RD_SEND: begin
          if (lastBit) begin
            if (evLeft != '0) begin
              rdPtr    <= (rdPtr == LAST_ADDR) ? '0 : rdPtr + ADDR_W'(1);
              evLeft   <= evLeft - CNT_W'(1);
              bitsLeft <= BIT_W'(EV_W);
            end else begin
              rdState <= RD_PASS;
            end
          end else begin
            bitsLeft <= bitsLeft - BIT_W'(1);
          end
        end
        default: rdState <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evs_datapath.sv
module evs_datapath
  import evs_pkg::*;
#(
  parameter int DEPTH    = 127,
  parameter int CHANNELS = 8,
  parameter int BCID_W   = 12,
  parameter int EV_W     = BCID_W + CHANNELS,
  parameter int CNT_W    = $clog2(DEPTH + 1),
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [BCID_W-1:0]   tag,
  input  logic [CHANNELS-1:0] hits,
  input  logic [CNT_W-1:0]    evCount,
  output logic                dataOut
);
  localparam int SH_W = (EV_W > CNT_W) ? EV_W : CNT_W;

  logic [EV_W-1:0] mem [DEPTH];
  logic [SH_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= {tag, hits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.loadCnt) shiftReg <= SH_W'(evCount) << (SH_W - CNT_W);
    else if (strb.loadEv)  shiftReg <= SH_W'(mem[rdAddr]) << (SH_W - EV_W);
    else if (strb.shiftEn) shiftReg <= shiftReg << 1;
  end

  assign dataOut = shiftReg[SH_W-1];
endmodule

// File: rtl/event_store_roll.sv
module event_store_roll
  import evs_pkg::*;
#(
  parameter int DEPTH    = 127,
  parameter int CHANNELS = 8,
  parameter int BCID_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rollMode,
  input  logic [1:0]          phase,
  input  logic                trigValid,
  input  logic [CHANNELS-1:0] trigHits,
  input  logic                tokenIn,
  output logic                memFull,
  output logic                dataOut,
  output logic                dataValid,
  output logic                tokenOut
);
  localparam int EV_W   = BCID_W + CHANNELS;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  strobe_t           strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [BCID_W-1:0] tag;
  logic [CNT_W-1:0]  evCount;

  evs_ctrl #(.DEPTH(DEPTH), .BCID_W(BCID_W), .EV_W(EV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rollMode(rollMode), .phase(phase),
    .trigValid(trigValid), .tokenIn(tokenIn), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .tag(tag), .evCount(evCount),
    .memFull(memFull), .dataValid(dataValid), .tokenOut(tokenOut)
  );

  evs_datapath #(.DEPTH(DEPTH), .CHANNELS(CHANNELS), .BCID_W(BCID_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .tag(tag), .hits(trigHits), .evCount(evCount), .dataOut(dataOut)
  );
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int DEPTH = 127
) (
  input logic       clk,
  input logic       rstN,
  input logic       rollMode,
  input logic [1:0] phase,
  input logic       trigValid,
  input logic       tokenIn,
  input logic       memFull,
  input logic       dataValid,
  input logic       tokenOut
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       lastPhase;
  logic [CNT_W-1:0] seenCnt;
  logic             entry;

  assign entry = (phase == 2'd1) && (lastPhase != 2'd1);

  // occupancy seen from the ports, saturating at DEPTH
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPhase <= 2'd0;
      seenCnt   <= '0;
    end else begin
      lastPhase <= phase;
      if (entry)
        seenCnt <= trigValid ? CNT_W'(1) : '0;
      else if (phase == 2'd1 && trigValid && seenCnt != CNT_W'(DEPTH))
        seenCnt <= seenCnt + CNT_W'(1);
    end
  end

  assert_full_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    memFull == (!rollMode && seenCnt == CNT_W'(DEPTH)));

  assert_entry_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    entry |=> !memFull);

  assert_token_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);

  assert_token_after_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataValid) |-> tokenOut);

  assert_no_start_outside_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!dataValid && phase != 2'd3) |=> !dataValid);

  assert_frame_in_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> phase == 2'd3);

  assert_no_token_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!dataValid && !tokenIn) |=> !tokenOut);
endmodule

bind event_store_roll evs_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .rollMode(rollMode), .phase(phase),
  .trigValid(trigValid), .tokenIn(tokenIn), .memFull(memFull),
  .dataValid(dataValid), .tokenOut(tokenOut)
);

// File: tb/event_store_roll_tb_top.sv
module event_store_roll_tb_top;
  localparam int DEPTH = 127;
  localparam int CH    = 8;
  localparam int TW    = 12;
  localparam int EVW   = TW + CH;
  localparam int CW    = 7;
  localparam int NSC   = 7;
  // rows: rollMode, trigger count, idle cycles between triggers
  localparam int SCEN [NSC][3] = '{
    '{0, 5, 0}, '{1, 5, 1}, '{0, 127, 0}, '{0, 140, 0},
    '{1, 140, 0}, '{1, 300, 2}, '{0, 0, 0}};

  logic clk = 0, rstN = 0, rollMode = 0, trigValid = 0, tokenIn = 0;
  logic [1:0] phase = 0;
  logic [CH-1:0] trigHits = 0;
  logic memFull, dataOut, dataValid, tokenOut;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int issTag [512];
  int issHit [512];
  bit rxBits [4096];
  int rxLen;
  bit rxTok;

  always #2.5 clk = ~clk;

  event_store_roll dut_i (
    .clk(clk), .rstN(rstN), .rollMode(rollMode), .phase(phase),
    .trigValid(trigValid), .trigHits(trigHits), .tokenIn(tokenIn),
    .memFull(memFull), .dataOut(dataOut), .dataValid(dataValid),
    .tokenOut(tokenOut));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int field(input int pos, input int w);
    int v = 0;
    for (int b = 0; b < w; b++) v = (v << 1) | int'(rxBits[pos + b]);
    return v;
  endfunction

  task automatic readFrame();
    phase = 2'd3; tokenIn = 1; step(); tokenIn = 0;
    rxLen = 0; rxTok = 0;
    for (int t = 0; t < 4000; t++) begin
      if (dataValid) begin rxBits[rxLen] = dataOut; rxLen++; end
      if (tokenOut) begin rxTok = 1; break; end
      step();
    end
    step();
  endtask

  task automatic runScen(input int roll, input int n, input int gap);
    int issued = 0, k = 0, keep, first, mism = -1, actV = 0, expV = 0;
    rollMode = roll[0]; phase = 2'd1;
    while (issued < n) begin
      trigValid = (k % (gap + 1) == 0);
      if (trigValid) begin
        issTag[issued] = k; issHit[issued] = (issued * 37 + 5) & 255;
        trigHits = CH'(issHit[issued]); issued++;
      end
      step(); k++;
    end
    trigValid = 0; step();
    check(memFull == (roll == 0 && n >= DEPTH), "R4 memFull after acquisition",
          int'(memFull), int'(roll == 0 && n >= DEPTH));
    phase = 2'd2; trigValid = 1; trigHits = 8'hFF; step(); trigValid = 0; step();
    readFrame();
    keep = (n < DEPTH) ? n : DEPTH;
    first = roll ? n - keep : 0;
    check(field(0, CW) == keep, "R6/R7 count field", field(0, CW), keep);
    check(rxLen == CW + keep * EVW, "R7 frame length", rxLen, CW + keep * EVW);
    for (int e = 0; e < keep && rxLen == CW + keep * EVW; e++) begin
      if (field(CW + e * EVW, TW) != issTag[first + e] ||
          field(CW + e * EVW + TW, CH) != issHit[first + e]) begin
        mism = e; actV = field(CW + e * EVW, EVW);
        expV = (issTag[first + e] << CH) | issHit[first + e]; break;
      end
    end
    check(mism < 0, roll ? "R1/R3 events oldest first" : "R1/R2 events in order", actV, expV);
    check(rxTok, "R8 token passed", int'(rxTok), 1);
    phase = 2'd0; step();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int seen;
    step(); step();
    check(!memFull && !dataValid && !tokenOut, "reset outputs idle",
          int'({memFull, dataValid, tokenOut}), 0);
    rstN = 1; step();

    for (int s = 0; s < NSC; s++) runScen(SCEN[s][0], SCEN[s][1], SCEN[s][2]);

    // R5: fill to full, then a new acquisition clears the flag
    runScen(0, 130, 0);
    phase = 2'd1; step();
    check(!memFull, "R5 memFull cleared on new acquisition", int'(memFull), 0);
    phase = 2'd0; step();

    // R9: token outside readout starts nothing
    phase = 2'd2; tokenIn = 1; step(); tokenIn = 0;
    seen = 0;
    for (int t = 0; t < 10; t++) begin
      if (dataValid || tokenOut) seen++;
      step();
    end
    check(seen == 0, "R9 token ignored outside readout", seen, 0);

    // R4: roll mode never flags full even with memory full
    runScen(1, 200, 0);
    check(!memFull, "R4 no full flag in roll mode", int'(memFull), 0);

    // R8: empty acquisition gives count-only frame with token
    runScen(1, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule